// File: doc/BRIEF.md
# Micro-op aware program counter sequencer

This block holds the instruction pointer state for a processor whose branches have one delay slot and whose complex instructions are expanded into a series of micro-operations. It keeps three addresses: the current instruction address, the following address and the one after that. It also keeps a micro-operation counter that steps through the micro-ops of an expanded instruction. From the current address and a running byte offset it forms the fetch address, so that an instruction longer than one fetch word can be collected over several fetches.

The block does nothing unless the advance strobe is high for a cycle. When it is, one of the following actions is chosen:

- A fault redirects the state to a handler address.
- A not-ready report from the predecoder holds the address and asks for one more fetch word.
- An expanded instruction steps its micro-op counter.
- Otherwise the address chain moves forward, to the branch target when a branch is taken.

Decode, address translation and memory sit outside the block.

Top module: `mc_pc_sequencer`

## Requirements
- R1: A synchronous reset sets the current address to 0, the following address to 4 and the one after to 8. The micro-op counter and the fetch offset go to 0, and the hold indication goes low.
- R2: The fetch address equals the current address with its two low bits forced to zero, plus the fetch offset.
- R3: An advance with no fault, outside an expanded instruction and with the predecoder not ready, keeps the current address. It raises the hold indication and adds 4 to the fetch offset.
- R4: Every advance that is not a hold clears the fetch offset to 0 and drops the hold indication.
- R5: A plain advance moves the current address to the following address and the following address to the one after. The last address becomes its old value plus 4.
- R6: A taken branch on a plain advance moves the current address to the delay-slot address. The following address becomes the branch target and the last address becomes the target plus 4.
- R7: An advance with the predecoder ready and the expanded-instruction flag set, but not the last-micro-op flag, keeps the current address and sets the micro-op counter to 1. Each later advance inside the expanded instruction keeps the address and adds 1 to the counter, whatever the predecoder reports.
- R8: An advance carrying the last-micro-op flag inside an expanded instruction leaves it, including a one-micro-op instruction that is entered and left at once. The micro-op counter returns to 0 and the address chain moves as in R5/R6.
- R9: An advance with the fault flag loads the vector into the current address, the vector plus 4 into the following address and the vector plus 8 into the last. It sets the micro-op counter to 0 and abandons any expanded instruction. The fault wins over every other input in that cycle.
- R10: With the advance strobe low, no output changes.
- R11: After any advance the following address and the one after it differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance strobe, one step per high cycle |
| fault_i | input | 1 | Fault on this step |
| fault_vec_i | input | AW | Handler address used on a fault |
| pd_ready_i | input | 1 | Predecoder has a whole instruction |
| macro_i | input | 1 | Decoded instruction expands into micro-ops |
| last_uop_i | input | 1 | Executing micro-op is the final one |
| br_taken_i | input | 1 | Branch taken on this step |
| br_target_i | input | AW | Branch target address |
| fetch_addr_o | output | AW | Address of the next fetch word |
| pc_o | output | AW | Current instruction address |
| upc_o | output | UW | Micro-op counter |
| stay_o | output | 1 | Current address held for more fetch bytes |

## Verification
A corrupted expanded-instruction flag shows up on the next advance. It either freezes the current address when it should move, or lets a predecoder not-ready report raise the hold indication inside an expanded instruction. A wrong following or last address stays hidden until one or two plain advances have passed, so the checks follow each redirect (fault, branch, micro-op exit) with at least two further steps. A stale fetch offset is visible at once on the fetch address, including after faults and branches.

// File: rtl/mc_pc_seq_pkg.sv
package mc_pc_seq_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_FAULT,
    ACT_STAY,
    ACT_UOP,
    ACT_NEXT
  } seq_act_e;
endpackage

// File: rtl/mc_pc_chain.sv
module mc_pc_chain
  import mc_pc_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_act_e      act,
  input  logic          br_taken,
  input  logic [AW-1:0] br_target,
  input  logic [AW-1:0] fault_vec,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] npc,
  output logic [AW-1:0] nnpc
);
  localparam logic [AW-1:0] STEP_V  = AW'(STEP);
  localparam logic [AW-1:0] STEP2_V = AW'(2 * STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      npc  <= STEP_V;
      nnpc <= STEP2_V;
    end else begin
      case (act)
        ACT_FAULT: begin
          pc   <= fault_vec;
          npc  <= fault_vec + STEP_V;
          nnpc <= fault_vec + STEP2_V;
        end
        ACT_NEXT: begin
          pc <= npc;
          if (br_taken) begin
            npc  <= br_target;
            nnpc <= br_target + STEP_V;
          end else begin
            npc  <= nnpc;
            nnpc <= nnpc + STEP_V;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mc_upc_unit.sv
module mc_upc_unit
  import mc_pc_seq_pkg::*;
#(
  parameter int UW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_act_e      act,
  output logic [UW-1:0] upc,
  output logic          in_macro
);
  logic [UW-1:0] nupc;

  always_ff @(posedge clk) begin
    if (rst) begin
      upc      <= '0;
      nupc     <= UW'(1);
      in_macro <= 1'b0;
    end else begin
      case (act)
        ACT_FAULT, ACT_NEXT: begin
          upc      <= '0;
          nupc     <= UW'(1);
          in_macro <= 1'b0;
        end
        ACT_UOP: begin
          upc      <= nupc;
          nupc     <= nupc + UW'(1);
          in_macro <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mc_fetch_off.sv
module mc_fetch_off
  import mc_pc_seq_pkg::*;
#(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_act_e      act,
  output logic [AW-1:0] off,
  output logic          stay
);
  always_ff @(posedge clk) begin
    if (rst) begin
      off  <= '0;
      stay <= 1'b0;
    end else if (act == ACT_STAY) begin
      off  <= off + AW'(STEP);
      stay <= 1'b1;
    end else if (act != ACT_HOLD) begin
      off  <= '0;
      stay <= 1'b0;
    end
  end
endmodule

// File: rtl/mc_pc_sequencer.sv
module mc_pc_sequencer
  import mc_pc_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int UW       = 8,
  parameter int IW_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_i,
  input  logic          fault_i,
  input  logic [AW-1:0] fault_vec_i,
  input  logic          pd_ready_i,
  input  logic          macro_i,
  input  logic          last_uop_i,
  input  logic          br_taken_i,
  input  logic [AW-1:0] br_target_i,
  output logic [AW-1:0] fetch_addr_o,
  output logic [AW-1:0] pc_o,
  output logic [UW-1:0] upc_o,
  output logic          stay_o
);
  localparam int            ALIGN_BITS = $clog2(IW_BYTES);
  localparam logic [AW-1:0] ALIGN_MASK = AW'(IW_BYTES - 1);

  seq_act_e      act;
  logic          in_macro;
  logic [AW-1:0] npc, nnpc, off;

  // Fault first, then an open macro-op, then predecoder readiness.
  always_comb begin
    if (!adv_i)                     act = ACT_HOLD;
    else if (fault_i)               act = ACT_FAULT;
    else if (in_macro)              act = last_uop_i ? ACT_NEXT : ACT_UOP;
    else if (!pd_ready_i)           act = ACT_STAY;
    else if (macro_i && !last_uop_i) act = ACT_UOP;
    else                            act = ACT_NEXT;
  end

  mc_pc_chain #(.AW(AW), .STEP(IW_BYTES)) u_chain (
    .clk(clk), .rst(rst), .act(act),
    .br_taken(br_taken_i), .br_target(br_target_i), .fault_vec(fault_vec_i),
    .pc(pc_o), .npc(npc), .nnpc(nnpc)
  );

  mc_upc_unit #(.UW(UW)) u_upc (
    .clk(clk), .rst(rst), .act(act), .upc(upc_o), .in_macro(in_macro)
  );

  mc_fetch_off #(.AW(AW), .STEP(IW_BYTES)) u_off (
    .clk(clk), .rst(rst), .act(act), .off(off), .stay(stay_o)
  );

  generate
    if (ALIGN_BITS > 0) begin : g_mask
      assign fetch_addr_o = (pc_o & ~ALIGN_MASK) + off;
    end else begin : g_nomask
      assign fetch_addr_o = pc_o + off;
    end
  endgenerate
endmodule

// File: rtl/mc_pc_sequencer_chk.sv
module mc_pc_sequencer_chk #(
  parameter int AW = 32,
  parameter int UW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          adv_i,
  input logic          fault_i,
  input logic [AW-1:0] fault_vec_i,
  input logic          pd_ready_i,
  input logic          last_uop_i,
  input logic          in_macro,
  input logic [AW-1:0] fetch_addr_o,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] npc,
  input logic [AW-1:0] nnpc,
  input logic [UW-1:0] upc_o,
  input logic          stay_o
);
  p_chain_distinct_r11: assert property (@(posedge clk) disable iff (rst)
    npc != nnpc);

  p_fault_load_r9: assert property (@(posedge clk) disable iff (rst)
    (adv_i && fault_i) |=> (pc_o == $past(fault_vec_i)) && (upc_o == '0) && !stay_o);

  p_stay_grow_r3: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !fault_i && !in_macro && !pd_ready_i) |=>
      stay_o && $stable(pc_o) && (fetch_addr_o == $past(fetch_addr_o) + AW'(4)));

  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !adv_i |=> $stable(pc_o) && $stable(upc_o) && $stable(fetch_addr_o) && $stable(stay_o));

  p_uop_step_r7: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !fault_i && in_macro && !last_uop_i) |=>
      $stable(pc_o) && (upc_o == $past(upc_o) + UW'(1)));

  p_uop_exit_r8: assert property (@(posedge clk) disable iff (rst)
    (adv_i && !fault_i && in_macro && last_uop_i) |=> (upc_o == '0) && !in_macro);
endmodule

bind mc_pc_sequencer mc_pc_sequencer_chk #(.AW(AW), .UW(UW)) u_chk (
  .clk(clk), .rst(rst), .adv_i(adv_i), .fault_i(fault_i), .fault_vec_i(fault_vec_i),
  .pd_ready_i(pd_ready_i), .last_uop_i(last_uop_i), .in_macro(in_macro),
  .fetch_addr_o(fetch_addr_o), .pc_o(pc_o), .npc(npc), .nnpc(nnpc),
  .upc_o(upc_o), .stay_o(stay_o)
);

// File: tb/mc_pc_sequencer_bench.sv
module mc_pc_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 18;

  typedef struct packed {
    logic [7:0]  req;
    logic        adv, flt, pd, mac, last, br;
    logic [31:0] tgt;
    logic [31:0] vec;
    logic [31:0] e_pc;
    logic [7:0]  e_upc;
    logic [31:0] e_fetch;
    logic        e_stay;
  } row_t;

  // fields: req, adv flt pd mac last br, target, vector, exp pc, upc, fetch, stay
  localparam row_t TBL [N] = '{
    '{8'd5,  1,0,1,0,0,0, 32'h0,   32'h0,   32'h4,   8'd0, 32'h4,   1'b0}, // R5
    '{8'd10, 0,0,0,0,0,0, 32'h0,   32'h0,   32'h4,   8'd0, 32'h4,   1'b0}, // R10
    '{8'd3,  1,0,0,0,0,0, 32'h0,   32'h0,   32'h4,   8'd0, 32'h8,   1'b1}, // R3
    '{8'd3,  1,0,0,0,0,0, 32'h0,   32'h0,   32'h4,   8'd0, 32'hC,   1'b1}, // R3
    '{8'd4,  1,0,1,0,0,0, 32'h0,   32'h0,   32'h8,   8'd0, 32'h8,   1'b0}, // R4
    '{8'd6,  1,0,1,0,0,1, 32'h40,  32'h0,   32'hC,   8'd0, 32'hC,   1'b0}, // R6 delay slot
    '{8'd6,  1,0,1,0,0,0, 32'h0,   32'h0,   32'h40,  8'd0, 32'h40,  1'b0}, // R6 target
    '{8'd7,  1,0,1,1,0,0, 32'h0,   32'h0,   32'h40,  8'd1, 32'h40,  1'b0}, // R7 enter
    '{8'd7,  1,0,0,0,0,0, 32'h0,   32'h0,   32'h40,  8'd2, 32'h40,  1'b0}, // R7 pd ignored
    '{8'd8,  1,0,1,0,1,0, 32'h0,   32'h0,   32'h44,  8'd0, 32'h44,  1'b0}, // R8
    '{8'd8,  1,0,1,1,1,0, 32'h0,   32'h0,   32'h48,  8'd0, 32'h48,  1'b0}, // R8 single uop
    '{8'd7,  1,0,1,1,0,0, 32'h0,   32'h0,   32'h48,  8'd1, 32'h48,  1'b0}, // R7
    '{8'd9,  1,1,1,0,1,0, 32'h0,   32'h103, 32'h103, 8'd0, 32'h100, 1'b0}, // R9 + R2 mask
    '{8'd2,  1,0,0,0,0,0, 32'h0,   32'h0,   32'h103, 8'd0, 32'h104, 1'b1}, // R2
    '{8'd9,  1,1,0,0,0,0, 32'h0,   32'h200, 32'h200, 8'd0, 32'h200, 1'b0}, // R9 over stay
    '{8'd9,  1,0,1,0,0,0, 32'h0,   32'h0,   32'h204, 8'd0, 32'h204, 1'b0}, // R9 npc
    '{8'd9,  1,0,1,0,0,0, 32'h0,   32'h0,   32'h208, 8'd0, 32'h208, 1'b0}, // R9 nnpc
    '{8'd10, 0,0,0,0,0,0, 32'h0,   32'h0,   32'h208, 8'd0, 32'h208, 1'b0}  // R10
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        adv_i = 0, fault_i = 0, pd_ready_i = 0, macro_i = 0, last_uop_i = 0, br_taken_i = 0;
  logic [31:0] fault_vec_i = '0, br_target_i = '0;
  logic [31:0] fetch_addr_o, pc_o;
  logic [7:0]  upc_o;
  logic        stay_o;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_pc_sequencer u_mc_pc_sequencer (
    .clk(clk), .rst(rst), .adv_i(adv_i), .fault_i(fault_i), .fault_vec_i(fault_vec_i),
    .pd_ready_i(pd_ready_i), .macro_i(macro_i), .last_uop_i(last_uop_i),
    .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .fetch_addr_o(fetch_addr_o), .pc_o(pc_o), .upc_o(upc_o), .stay_o(stay_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [31:0] p, input logic [7:0] u,
                         input logic [31:0] f, input logic s);
    chk(tag, "pc", pc_o, p);
    chk(tag, "upc", {24'd0, upc_o}, {24'd0, u});
    chk(tag, "fetch", fetch_addr_o, f);
    chk(tag, "stay", {31'd0, stay_o}, {31'd0, s});
  endtask

  task automatic step(input logic a, input logic f, input logic pd, input logic m,
                      input logic l, input logic b, input logic [31:0] t, input logic [31:0] v);
    @(negedge clk);
    adv_i = a; fault_i = f; pd_ready_i = pd; macro_i = m; last_uop_i = l;
    br_taken_i = b; br_target_i = t; fault_vec_i = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1 chk_all("R1", 32'h0, 8'd0, 32'h0, 1'b0);

    for (int i = 0; i < N; i++) begin
      step(TBL[i].adv, TBL[i].flt, TBL[i].pd, TBL[i].mac, TBL[i].last, TBL[i].br,
           TBL[i].tgt, TBL[i].vec);
      chk_all($sformatf("R%0d row%0d", TBL[i].req, i), TBL[i].e_pc, TBL[i].e_upc,
              TBL[i].e_fetch, TBL[i].e_stay);
    end

    // R1: reset in mid-flight from a held, in-macro state
    step(1,0,1,1,0,0, 32'h0, 32'h0);
    step(1,0,0,0,0,0, 32'h0, 32'h0);
    @(negedge clk) begin rst = 1'b1; adv_i = 1'b0; end
    @(posedge clk); #1;
    @(negedge clk) rst = 1'b0;
    #1 chk_all("R1 mid", 32'h0, 8'd0, 32'h0, 1'b0);
    // R1/R5: chain reloaded as 4 and 8
    step(1,0,1,0,0,0, 32'h0, 32'h0);
    chk_all("R1 npc", 32'h4, 8'd0, 32'h4, 1'b0);
    step(1,0,1,0,0,0, 32'h0, 32'h0);
    chk_all("R1 nnpc", 32'h8, 8'd0, 32'h8, 1'b0);
    step(1,0,1,0,0,0, 32'h0, 32'h0);
    chk_all("R5 nnpc+4", 32'hC, 8'd0, 32'hC, 1'b0);

    // R7/R9: fault inside a macro-op abandons it; a not-ready then stays
    step(1,0,1,1,0,0, 32'h0, 32'h0);
    step(1,0,1,0,0,0, 32'h0, 32'h0);
    chk_all("R7 upc2", 32'hC, 8'd2, 32'hC, 1'b0);
    step(1,1,1,0,0,1, 32'h80, 32'h300);
    chk_all("R9 in macro", 32'h300, 8'd0, 32'h300, 1'b0);
    step(1,0,0,0,0,0, 32'h0, 32'h0);
    chk_all("R9 macro dropped", 32'h300, 8'd0, 32'h304, 1'b1);

    // R4/R6: taken branch clears an accumulated offset
    step(1,0,1,0,0,1, 32'h500, 32'h0);
    chk_all("R4 R6", 32'h304, 8'd0, 32'h304, 1'b0);
    step(1,0,1,0,0,0, 32'h0, 32'h0);
    chk_all("R6 target", 32'h500, 8'd0, 32'h500, 1'b0);
    step(1,0,1,0,0,0, 32'h0, 32'h0);
    chk_all("R6 target+4", 32'h504, 8'd0, 32'h504, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule